// File: doc/BRIEF.md
# In-Switch Tree Reduction Aggregator

This block is the aggregation engine of one switch node in a reduction tree. Each of `K` child links sends vector segments of four 32-bit elements, one element per beat. Each beat carries a collective ID, a segment number and an element index. The engine keeps one accumulator slot for each (collective, segment) pair. It adds every arriving element into its slot with saturating two's-complement arithmetic. A `K`-bit arrival bitmap records which children have delivered a complete contribution to that slot.

When all `K` bits of a slot are set, the slot is complete. A non-root node streams the reduced segment out of its single upstream port. A node with `is_root` high streams it instead to every child output port at the same time, as one replicated beat. After the last element of the segment is handed off, the slot is cleared for reuse. On the way back down, a non-root node copies each beat from its upstream input onto all child outputs without touching its accumulators.

Top module: `tree_reduce_node`

## Requirements
- R1: After reset, `up_out_valid`, every bit of `c_out_valid` and `dup_err` are low.
- R2: A completed segment leaves as four beats with element indices 0, 1, 2, 3 in that order. Each beat carries the slot's collective ID and segment number, and its data is the element-wise sum of the children's contributions.
- R3: Only the reduced result is emitted. No individual child contribution appears on any output.
- R4: A slot produces no output until all `K` children have each delivered element index 3 (the last element) for it.
- R5: A beat from a child that has already completed its contribution to a slot is dropped. The slot's sum is unchanged, and `dup_err` goes high for one cycle for each dropped beat.
- R6: Addition saturates: a sum above 0x7FFFFFFF gives 0x7FFFFFFF, and a sum below 0x80000000 gives 0x80000000.
- R7: Segments of different collectives and different segment numbers accumulate independently, even when their beats are interleaved.
- R8: Once a slot's result has been sent, the slot starts again from zero with an empty bitmap.
- R9: While the selected output is not ready, the output beat is held stable and child inputs to other slots are still accepted. The held segment is sent before any segment that completes later.
- R10: With `is_root` high, completed segments go out on the child outputs, and `up_out_valid` stays low.
- R11: The child output valids are always all high or all low. A beat advances only when every child output is ready.
- R12: With `is_root` low, each beat accepted on `up_in` appears unchanged on the child outputs, and the accumulators are left untouched.
- R13: With `is_root` high, `up_in` is always ready, and its beats are discarded without producing any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_root | input | 1 | Node is the tree root (quasi-static) |
| c_in_valid | input | K | Per-child input beat valid |
| c_in_ready | output | K | Per-child input beat accepted |
| c_in_data | input | K*W | Per-child element value |
| c_in_cid | input | K*CIDW | Per-child collective ID |
| c_in_seg | input | K*SEGW | Per-child segment number |
| c_in_eidx | input | K*EW | Per-child element index |
| up_out_valid | output | 1 | Reduced beat to parent valid |
| up_out_ready | input | 1 | Parent accepts beat |
| up_out_data | output | W | Reduced element |
| up_out_cid | output | CIDW | Collective ID of reduced beat |
| up_out_seg | output | SEGW | Segment number of reduced beat |
| up_out_eidx | output | EW | Element index of reduced beat |
| up_in_valid | input | 1 | Result beat from parent valid |
| up_in_ready | output | 1 | Result beat from parent accepted |
| up_in_data | input | W | Result element from parent |
| up_in_cid | input | CIDW | Collective ID from parent |
| up_in_seg | input | SEGW | Segment number from parent |
| up_in_eidx | input | EW | Element index from parent |
| c_out_valid | output | K | Per-child output valid (replicated) |
| c_out_ready | input | K | Per-child output ready |
| c_out_data | output | W | Shared element to children |
| c_out_cid | output | CIDW | Shared collective ID to children |
| c_out_seg | output | SEGW | Shared segment number to children |
| c_out_eidx | output | EW | Shared element index to children |
| dup_err | output | 1 | One-cycle pulse per dropped duplicate beat |

## Verification
The bench resends a full segment from a child that has already contributed to it. A design without the bitmap guard would add that child twice, and the reported sum would be too large. It fills a slot from only two of three children to catch an engine that releases a segment early. It drives sums past both ends of the signed range, which a wrapping adder would turn into values of the opposite sign. It stalls the parent port while other slots finish, and it holds back one child's ready at the root, where a broken design would lose, reorder or partly deliver beats. Finally, it sends the same slot twice in a row, which exposes a slot that is not cleared after it is sent.

// File: rtl/tree_reduce_pkg.sv
// Shared types for the tree reduction node.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tree_reduce_pkg;
    // Which port a completed segment leaves on.
    typedef enum logic {
        ROUTE_UP   = 1'b0,
        ROUTE_DOWN = 1'b1
    } route_e;
endpackage

// File: rtl/tr_rr_arbiter.sv
// Round-robin grant of one child input beat per cycle.
// Assumes requests may change every cycle; the grant is combinational.
module tr_rr_arbiter #(
    parameter int K = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [K-1:0] req,
    output logic [K-1:0] grant
);
    localparam int KW = (K > 1) ? $clog2(K) : 1;

    logic [KW-1:0] last_q;
    logic [KW-1:0] gidx;

    // Search from the child after the last winner for the first request.
    always_comb begin
        grant = '0;
        gidx  = '0;
        for (int o = 1; o <= K; o++) begin
            int idx;
            idx = (int'(last_q) + o) % K;
            if (req[idx] && grant == '0) begin
                grant[idx] = 1'b1;
                gidx       = KW'(idx);
            end
        end
    end

    // Remember the last winner so the next search starts after it.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_q <= KW'(K - 1);
        else if (|grant)    last_q <= gidx;
    end

    assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_requested_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
endmodule

// File: rtl/tr_slot_bank.sv
// Accumulator and arrival bitmap storage, one slot per (collective, segment).
// Accepts one element write per cycle and saturates each sum. It drops beats
// from a child whose bit is already set and pulses dup_err for each one.
// Assumes the clear port only names a complete slot, which takes no writes.
module tr_slot_bank #(
    parameter int K     = 3,
    parameter int W     = 32,
    parameter int ELEMS = 4,
    parameter int NSLOT = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(K>1?K:2)-1:0] wr_child,
    input  logic [$clog2(NSLOT)-1:0]  wr_slot,
    input  logic [$clog2(ELEMS)-1:0]  wr_eidx,
    input  logic [W-1:0]              wr_data,
    input  logic                      clr_en,
    input  logic [$clog2(NSLOT)-1:0]  clr_slot,
    input  logic [$clog2(NSLOT)-1:0]  rd_slot,
    input  logic [$clog2(ELEMS)-1:0]  rd_eidx,
    output logic [W-1:0]              rd_data,
    output logic [NSLOT-1:0]          full,
    output logic                      dup_err
);
    localparam int EW = $clog2(ELEMS);
    localparam logic [EW-1:0] LAST = EW'(ELEMS - 1);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] acc [NSLOT][ELEMS];
    logic [K-1:0] bmap [NSLOT];
    logic         dup_hit;

    function automatic logic [W-1:0] sat_add(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] s;
        s = {a[W-1], a} + {b[W-1], b};
        if (s[W] != s[W-1]) return s[W] ? SMIN : SMAX;
        return s[W-1:0];
    endfunction

    // A slot is complete when every child bit is set.
    always_comb begin
        for (int s = 0; s < NSLOT; s++) full[s] = &bmap[s];
    end

    assign dup_hit = wr_en && bmap[wr_slot][wr_child];
    assign rd_data = acc[rd_slot][rd_eidx];

    // Clear sent slots, accumulate fresh beats, flag duplicate beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSLOT; s++) begin
                bmap[s] <= '0;
                for (int e = 0; e < ELEMS; e++) acc[s][e] <= '0;
            end
            dup_err <= 1'b0;
        end else begin
            dup_err <= dup_hit;
            if (clr_en) begin
                bmap[clr_slot] <= '0;
                for (int e = 0; e < ELEMS; e++) acc[clr_slot][e] <= '0;
            end
            if (wr_en && !dup_hit) begin
                acc[wr_slot][wr_eidx] <= sat_add(acc[wr_slot][wr_eidx], wr_data);
                if (wr_eidx == LAST) bmap[wr_slot][wr_child] <= 1'b1;
            end
        end
    end

    assert_dup_flagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dup_hit |=> dup_err);
    assert_clear_only_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> full[clr_slot]);
endmodule

// File: rtl/tr_emitter.sv
// Picks the lowest-numbered complete slot and walks its elements out in
// order, one per accepted beat. On the last beat it orders the slot cleared.
// Assumes the selected slot stays complete until it is cleared.
module tr_emitter #(
    parameter int ELEMS = 4,
    parameter int NSLOT = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSLOT-1:0]         full,
    input  logic                     fire,
    output logic                     valid,
    output logic [$clog2(NSLOT)-1:0] slot,
    output logic [$clog2(ELEMS)-1:0] eidx,
    output logic                     clr_en
);
    localparam int SLW = $clog2(NSLOT);
    localparam int EW  = $clog2(ELEMS);
    localparam logic [EW-1:0] LAST = EW'(ELEMS - 1);

    logic [SLW-1:0] pick;
    logic           any_full;

    // Lowest-index complete slot.
    always_comb begin
        pick     = '0;
        any_full = 1'b0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (full[s]) begin
                pick     = SLW'(s);
                any_full = 1'b1;
            end
        end
    end

    assign clr_en = valid && fire && (eidx == LAST);

    // Hold one segment at a time and step through its elements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            slot  <= '0;
            eidx  <= '0;
        end else if (!valid) begin
            if (any_full) begin
                valid <= 1'b1;
                slot  <= pick;
                eidx  <= '0;
            end
        end else if (fire) begin
            if (eidx == LAST) valid <= 1'b0;
            else              eidx  <= eidx + 1'b1;
        end
    end

    assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !fire) |=> (valid && $stable(slot) && $stable(eidx)));
    assert_emit_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> full[slot]);
endmodule

// File: rtl/tree_reduce_node.sv
// One switch node of a reduction tree. It sums the children's segments into
// per-(collective, segment) slots. A non-root node sends complete segments
// upstream and copies results from the parent to all children. A root node
// sends complete segments to all children itself.
// Assumes NCOLL, NSEG and ELEMS are powers of two, that each child sends a
// segment's elements in index order, and that is_root changes only when idle.
module tree_reduce_node
    import tree_reduce_pkg::*;
#(
    parameter int K     = 3,
    parameter int W     = 32,
    parameter int ELEMS = 4,
    parameter int NCOLL = 4,
    parameter int NSEG  = 4,
    parameter int CIDW  = $clog2(NCOLL),
    parameter int SEGW  = $clog2(NSEG),
    parameter int EW    = $clog2(ELEMS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_root,
    input  logic [K-1:0]      c_in_valid,
    output logic [K-1:0]      c_in_ready,
    input  logic [K*W-1:0]    c_in_data,
    input  logic [K*CIDW-1:0] c_in_cid,
    input  logic [K*SEGW-1:0] c_in_seg,
    input  logic [K*EW-1:0]   c_in_eidx,
    output logic              up_out_valid,
    input  logic              up_out_ready,
    output logic [W-1:0]      up_out_data,
    output logic [CIDW-1:0]   up_out_cid,
    output logic [SEGW-1:0]   up_out_seg,
    output logic [EW-1:0]     up_out_eidx,
    input  logic              up_in_valid,
    output logic              up_in_ready,
    input  logic [W-1:0]      up_in_data,
    input  logic [CIDW-1:0]   up_in_cid,
    input  logic [SEGW-1:0]   up_in_seg,
    input  logic [EW-1:0]     up_in_eidx,
    output logic [K-1:0]      c_out_valid,
    input  logic [K-1:0]      c_out_ready,
    output logic [W-1:0]      c_out_data,
    output logic [CIDW-1:0]   c_out_cid,
    output logic [SEGW-1:0]   c_out_seg,
    output logic [EW-1:0]     c_out_eidx,
    output logic              dup_err
);
    localparam int KW    = (K > 1) ? $clog2(K) : 1;
    localparam int NSLOT = NCOLL * NSEG;
    localparam int SLW   = CIDW + SEGW;

    logic [K-1:0]    grant;
    logic [KW-1:0]   wchild;
    logic [SLW-1:0]  wslot;
    logic [EW-1:0]   weidx;
    logic [W-1:0]    wdata;
    logic [NSLOT-1:0] full;
    logic            em_valid, em_fire, clr_en;
    logic [SLW-1:0]  em_slot;
    logic [EW-1:0]   em_eidx;
    logic [W-1:0]    em_data;
    route_e          route;

    tr_rr_arbiter #(.K(K)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(c_in_valid), .grant(grant)
    );

    assign c_in_ready = grant;

    // Route the granted child's beat fields into the slot bank.
    always_comb begin
        wchild = '0;
        wslot  = '0;
        weidx  = '0;
        wdata  = '0;
        for (int i = 0; i < K; i++) begin
            if (grant[i]) begin
                wchild = KW'(i);
                wslot  = {c_in_cid[i*CIDW +: CIDW], c_in_seg[i*SEGW +: SEGW]};
                weidx  = c_in_eidx[i*EW +: EW];
                wdata  = c_in_data[i*W +: W];
            end
        end
    end

    tr_slot_bank #(.K(K), .W(W), .ELEMS(ELEMS), .NSLOT(NSLOT)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(|grant), .wr_child(wchild), .wr_slot(wslot),
        .wr_eidx(weidx), .wr_data(wdata),
        .clr_en(clr_en), .clr_slot(em_slot),
        .rd_slot(em_slot), .rd_eidx(em_eidx), .rd_data(em_data),
        .full(full), .dup_err(dup_err)
    );

    tr_emitter #(.ELEMS(ELEMS), .NSLOT(NSLOT)) u_emit (
        .clk(clk), .rst_n(rst_n), .full(full), .fire(em_fire),
        .valid(em_valid), .slot(em_slot), .eidx(em_eidx), .clr_en(clr_en)
    );

    assign route   = is_root ? ROUTE_DOWN : ROUTE_UP;
    assign em_fire = (route == ROUTE_DOWN) ? (&c_out_ready) : up_out_ready;

    // Upstream port carries reduced segments of a non-root node only.
    assign up_out_valid = em_valid && (route == ROUTE_UP);
    assign up_out_data  = em_data;
    assign up_out_cid   = em_slot[SLW-1:SEGW];
    assign up_out_seg   = em_slot[SEGW-1:0];
    assign up_out_eidx  = em_eidx;

    // Child outputs: one beat replicated to all children, from the emitter at
    // the root or straight from the parent otherwise.
    always_comb begin
        if (route == ROUTE_DOWN) begin
            c_out_valid = {K{em_valid}};
            c_out_data  = em_data;
            c_out_cid   = em_slot[SLW-1:SEGW];
            c_out_seg   = em_slot[SEGW-1:0];
            c_out_eidx  = em_eidx;
            up_in_ready = 1'b1;
        end else begin
            c_out_valid = {K{up_in_valid}};
            c_out_data  = up_in_data;
            c_out_cid   = up_in_cid;
            c_out_seg   = up_in_seg;
            c_out_eidx  = up_in_eidx;
            up_in_ready = &c_out_ready;
        end
    end

    assert_root_no_upstream_R10: assert property (@(posedge clk) disable iff (!rst_n)
        is_root |-> !up_out_valid);
    assert_replicated_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (c_out_valid == '0) || (&c_out_valid));
    assert_stall_holds_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_out_valid && !up_out_ready && $stable(is_root)) |=> (up_out_valid && $stable(up_out_data)));
endmodule

// File: tb/sim_tree_reduce_node.sv
`timescale 1ns/100ps
module sim_tree_reduce_node;
    localparam int K = 3, W = 32, CIDW = 2, SEGW = 2, EW = 2;

    logic clk = 1'b0, rst_n = 1'b0, is_root = 1'b0;
    logic [K-1:0] c_in_valid = '0, c_in_ready;
    logic [K*W-1:0] c_in_data = '0;
    logic [K*CIDW-1:0] c_in_cid = '0;
    logic [K*SEGW-1:0] c_in_seg = '0;
    logic [K*EW-1:0] c_in_eidx = '0;
    logic up_out_valid, up_out_ready = 1'b1;
    logic [W-1:0] up_out_data;
    logic [CIDW-1:0] up_out_cid;
    logic [SEGW-1:0] up_out_seg;
    logic [EW-1:0] up_out_eidx;
    logic up_in_valid = 1'b0, up_in_ready;
    logic [W-1:0] up_in_data = '0;
    logic [CIDW-1:0] up_in_cid = '0;
    logic [SEGW-1:0] up_in_seg = '0;
    logic [EW-1:0] up_in_eidx = '0;
    logic [K-1:0] c_out_valid, c_out_ready = '1;
    logic [W-1:0] c_out_data;
    logic [CIDW-1:0] c_out_cid;
    logic [SEGW-1:0] c_out_seg;
    logic [EW-1:0] c_out_eidx;
    logic dup_err;

    int checks = 0, failures = 0;
    int up_n = 0, dn_n = 0, dup_n = 0, rep_bad = 0;
    logic [W-1:0] up_d [64], dn_d [64];
    logic [CIDW+SEGW+EW-1:0] up_t [64], dn_t [64];

    always #2.5 clk = ~clk;

    tree_reduce_node u0 (.*);

    // Monitor: record handshakes just before each rising edge.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (up_out_valid && up_out_ready && up_n < 64) begin
                up_d[up_n] = up_out_data;
                up_t[up_n] = {up_out_cid, up_out_seg, up_out_eidx};
                up_n++;
            end
            if (c_out_valid[0] && (&c_out_ready) && dn_n < 64) begin
                dn_d[dn_n] = c_out_data;
                dn_t[dn_n] = {c_out_cid, c_out_seg, c_out_eidx};
                dn_n++;
            end
            if (dup_err) dup_n++;
            if (c_out_valid != '0 && c_out_valid != '1) rep_bad++;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [W-1:0] sat(input longint s);
        if (s > 64'sh7FFFFFFF) return 32'h7FFFFFFF;
        if (s < -64'sh80000000) return 32'h80000000;
        return s[W-1:0];
    endfunction

    task automatic send_seg(input int ch, input int cid, input int seg,
                            input logic [W-1:0] v0, v1, v2, v3);
        logic [W-1:0] v [4];
        v = '{v0, v1, v2, v3};
        for (int e = 0; e < 4; e++) begin
            @(negedge clk);
            c_in_valid[ch] = 1'b1;
            c_in_data[ch*W +: W] = v[e];
            c_in_cid[ch*CIDW +: CIDW] = CIDW'(cid);
            c_in_seg[ch*SEGW +: SEGW] = SEGW'(seg);
            c_in_eidx[ch*EW +: EW] = EW'(e);
            #1;
            while (c_in_ready[ch] !== 1'b1) begin @(negedge clk); #1; end
            @(posedge clk);
        end
        @(negedge clk);
        c_in_valid[ch] = 1'b0;
    endtask

    task automatic push_up(input logic [W-1:0] d, input int cid, input int seg, input int e);
        @(negedge clk);
        up_in_valid = 1'b1; up_in_data = d;
        up_in_cid = CIDW'(cid); up_in_seg = SEGW'(seg); up_in_eidx = EW'(e);
        #1;
        while (up_in_ready !== 1'b1) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        up_in_valid = 1'b0;
    endtask

    task automatic chk_seg(input bit down, input int base, input int cid, input int seg,
                           input logic [W-1:0] e0, e1, e2, e3, input string req);
        logic [W-1:0] ex [4];
        ex = '{e0, e1, e2, e3};
        for (int e = 0; e < 4; e++) begin
            logic [W-1:0] d;
            logic [CIDW+SEGW+EW-1:0] t;
            d = down ? dn_d[base+e] : up_d[base+e];
            t = down ? dn_t[base+e] : up_t[base+e];
            chk(d == ex[e], req, d, ex[e]);
            chk(t == {CIDW'(cid), SEGW'(seg), EW'(e)}, req, t, {CIDW'(cid), SEGW'(seg), EW'(e)});
        end
    endtask

    task automatic clear_counts;
        up_n = 0; dn_n = 0; dup_n = 0;
    endtask

    task automatic t_reset;
        chk(up_out_valid == 1'b0, "R1", up_out_valid, 0);
        chk(c_out_valid == '0, "R1", c_out_valid, 0);
        chk(dup_err == 1'b0, "R1", dup_err, 0);
    endtask

    // R2/R3: three children, one segment, sum upstream only.
    task automatic t_basic;
        clear_counts();
        fork
            send_seg(0, 1, 2, 1, 2, 3, 4);
            send_seg(1, 1, 2, 10, 20, 30, 40);
            send_seg(2, 1, 2, 100, 200, 300, -5);
        join
        cyc(12);
        chk(up_n == 4, "R3", up_n, 4);
        chk(dn_n == 0, "R3", dn_n, 0);
        chk_seg(0, 0, 1, 2, 111, 222, 333, 39, "R2");
    endtask

    // R4: two of three children give no output; the third releases it.
    task automatic t_wait_all;
        clear_counts();
        fork
            send_seg(0, 0, 3, 5, 5, 5, 5);
            send_seg(2, 0, 3, 7, 7, 7, 7);
        join
        cyc(12);
        chk(up_n == 0, "R4", up_n, 0);
        send_seg(1, 0, 3, 1, 2, 3, 4);
        cyc(12);
        chk(up_n == 4, "R4", up_n, 4);
        chk_seg(0, 0, 0, 3, 13, 14, 15, 16, "R4");
    endtask

    // R5: child 0 resends the whole segment; it is dropped and flagged.
    task automatic t_dup;
        clear_counts();
        send_seg(0, 2, 0, 1, 1, 1, 1);
        send_seg(0, 2, 0, 50, 50, 50, 50);
        cyc(3);
        chk(dup_n == 4, "R5", dup_n, 4);
        chk(up_n == 0, "R5", up_n, 0);
        fork
            send_seg(1, 2, 0, 2, 2, 2, 2);
            send_seg(2, 2, 0, 3, 3, 3, 3);
        join
        cyc(12);
        chk(up_n == 4, "R5", up_n, 4);
        chk_seg(0, 0, 2, 0, 6, 6, 6, 6, "R5");
    endtask

    // R6: sums past both ends of the signed range clamp.
    task automatic t_sat;
        clear_counts();
        fork
            send_seg(0, 3, 1, 32'h70000000, 32'h90000000, 32'h7FFFFFF0, 1);
            send_seg(1, 3, 1, 32'h70000000, 32'h90000000, 5, 2);
            send_seg(2, 3, 1, 32'h70000000, 32'h90000000, 5, 3);
        join
        cyc(12);
        chk_seg(0, 0, 3, 1, 32'h7FFFFFFF, 32'h80000000, 32'h7FFFFFFA, 6, "R6");
    endtask

    // R7: two collectives interleaved across children.
    task automatic t_separate;
        clear_counts();
        fork
            begin send_seg(0, 1, 0, 1, 1, 1, 1); send_seg(0, 2, 1, 9, 9, 9, 9); end
            begin send_seg(1, 2, 1, 8, 8, 8, 8); send_seg(1, 1, 0, 2, 2, 2, 2); end
            begin send_seg(2, 1, 0, 4, 4, 4, 4); send_seg(2, 2, 1, 7, 7, 7, 7); end
        join
        cyc(16);
        chk(up_n == 8, "R7", up_n, 8);
        if (up_t[0][CIDW+SEGW+EW-1 -: CIDW] == 2'd1) begin
            chk_seg(0, 0, 1, 0, 7, 7, 7, 7, "R7");
            chk_seg(0, 4, 2, 1, 24, 24, 24, 24, "R7");
        end else begin
            chk_seg(0, 0, 2, 1, 24, 24, 24, 24, "R7");
            chk_seg(0, 4, 1, 0, 7, 7, 7, 7, "R7");
        end
    endtask

    // R8: the same slot used twice restarts from zero.
    task automatic t_reuse;
        for (int r = 0; r < 2; r++) begin
            clear_counts();
            fork
                send_seg(0, 3, 3, r + 1, 0, 0, 0);
                send_seg(1, 3, 3, r + 1, 0, 0, 0);
                send_seg(2, 3, 3, r + 1, 0, 0, 1);
            join
            cyc(12);
            chk_seg(0, 0, 3, 3, 3 * (r + 1), 0, 0, 1, "R8");
        end
    endtask

    // R9: stalled parent holds its beat; another slot still fills.
    task automatic t_stall;
        logic [W-1:0] held;
        clear_counts();
        up_out_ready = 1'b0;
        fork
            send_seg(0, 0, 0, 1, 2, 3, 4);
            send_seg(1, 0, 0, 1, 2, 3, 4);
            send_seg(2, 0, 0, 1, 2, 3, 4);
        join
        cyc(4);
        #2 held = up_out_data;
        chk(up_out_valid == 1'b1, "R9", up_out_valid, 1);
        fork
            send_seg(0, 0, 1, 5, 5, 5, 5);
            send_seg(1, 0, 1, 5, 5, 5, 5);
            send_seg(2, 0, 1, 5, 5, 5, 5);
        join
        cyc(4);
        #2 chk(up_out_valid && up_out_data == held && up_out_eidx == 0, "R9", up_out_data, held);
        @(negedge clk) up_out_ready = 1'b1;
        cyc(16);
        chk(up_n == 8, "R9", up_n, 8);
        chk_seg(0, 0, 0, 0, 3, 6, 9, 12, "R9");
        chk_seg(0, 4, 0, 1, 15, 15, 15, 15, "R9");
    endtask

    // R10/R11: root sends to all children, waits for every ready.
    task automatic t_root;
        clear_counts();
        is_root = 1'b1;
        c_out_ready = 3'b011;
        fork
            send_seg(0, 2, 2, 1, 1, 1, 1);
            send_seg(1, 2, 2, 2, 2, 2, 2);
            send_seg(2, 2, 2, 3, 3, 3, 3);
        join
        cyc(8);
        chk(dn_n == 0, "R11", dn_n, 0);
        chk(c_out_valid == 3'b111, "R11", c_out_valid, 3'b111);
        @(negedge clk) c_out_ready = 3'b111;
        cyc(12);
        chk(dn_n == 4, "R10", dn_n, 4);
        chk(up_n == 0, "R10", up_n, 0);
        chk_seg(1, 0, 2, 2, 6, 6, 6, 6, "R10");
        chk(rep_bad == 0, "R11", rep_bad, 0);
    endtask

    // R13: root discards parent beats.
    task automatic t_root_ignore;
        clear_counts();
        push_up(32'hDEAD, 1, 1, 0);
        cyc(6);
        chk(dn_n == 0 && up_n == 0, "R13", dn_n + up_n, 0);
        is_root = 1'b0;
    endtask

    // R12: non-root passes parent beats down; partial sums survive.
    task automatic t_passthru;
        clear_counts();
        send_seg(0, 1, 3, 4, 4, 4, 4);
        push_up(32'hCAFE0001, 2, 3, 1);
        push_up(32'hCAFE0002, 2, 3, 2);
        cyc(3);
        chk(dn_n == 2, "R12", dn_n, 2);
        chk(dn_d[0] == 32'hCAFE0001 && dn_t[0] == {2'd2, 2'd3, 2'd1}, "R12", dn_d[0], 32'hCAFE0001);
        chk(dn_d[1] == 32'hCAFE0002 && dn_t[1] == {2'd2, 2'd3, 2'd2}, "R12", dn_d[1], 32'hCAFE0002);
        fork
            send_seg(1, 1, 3, 1, 1, 1, 1);
            send_seg(2, 1, 3, 1, 1, 1, 1);
        join
        cyc(12);
        chk(up_n == 4, "R12", up_n, 4);
        chk_seg(0, 0, 1, 3, 6, 6, 6, 6, "R12");
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(4);
        @(negedge clk) rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_basic();
        t_wait_all();
        t_dup();
        t_sat();
        t_separate();
        t_reuse();
        t_stall();
        t_root();
        t_root_ignore();
        t_passthru();
        chk(sat(64'sd5) == 5, "R6", sat(64'sd5), 5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule